// File: doc/BRIEF.md
# Two-level cascaded interrupt aggregator

This block merges the interrupt causes of a host controller into one active-high interrupt pin. There are two tiers of causes. The inner (secondary) tier records six event pulses in a sticky status register. Its set bits that are also enabled are ORed together, and the result is qualified by a master enable bit. While the qualified result is high, it sets one bit of the outer (primary) tier. That tier also records five further event pulses. It masks and ORs its own status in the same way.

The outer OR does not drive the pin directly. It passes through a hold stage whose update enable is a pin-enable configuration bit. While that bit is 1 the pin follows the outer OR one cycle later. While it is 0 the pin keeps its last value. Software can therefore freeze the pin. To park the pin low, software clears the outer status first and only then drops the pin enable.

Software reaches the registers through a single-cycle write strobe and a combinational read port that share one address bus.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: A pulse on `sec_evt_i[k]` sets secondary status bit 0 for k=0 and bit k+1 for k=1..5, so the valid bits are 0 and 2 to 6. Every other secondary status bit reads 0.
- R3: Status bits in both tiers stay set until software clears them. A write of 1 to a status bit clears it, and a write of 0 leaves it unchanged. If an event arrives in the same cycle as the clear, the event wins and the bit stays set.
- R4: The secondary result is 1 only when at least one status bit and its enable bit are both 1, and secondary enable bit 31 (the master enable) is also 1.
- R5: While the secondary result is 1, primary status bit 0 is set on every clock edge. A clear of bit 0 therefore has no effect while the secondary cause is still pending.
- R6: A pulse on `pri_evt_i[k]` sets primary status bit k+1 for k=0..4.
- R7: The primary result is the OR over bits 0 to 5 of the primary status ANDed with the primary enable.
- R8: While configuration bit 0 is 1, `irq_o` takes the primary result of the previous cycle.
- R9: While configuration bit 0 is 0, `irq_o` does not change, whatever events or writes arrive.
- R10: Software can park the pin low with this sequence: set configuration bit 0 to 1, clear the whole primary status, then write configuration bit 0 to 0. After that, `irq_o` stays 0 even when new primary events are recorded.
- R11: The register addresses are as follows. 0 is the secondary status. 1 is the secondary enable, with writable bits 0, 2 to 6 and 31. 2 is the primary status, bits 0 to 5. 3 is the primary enable, bits 0 to 5. 4 is the configuration, bit 0. Bits that cannot be written read 0, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_evt_i | input | 6 | Secondary event pulses |
| pri_evt_i | input | 5 | Primary event pulses (primary bits 1 to 5) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt pin, active high |

## Verification
The first part drives directed patterns. Pulsing all six secondary inputs at once separates correct bit placement from a shifted mapping. Enabling a cause without the master bit, and then with it, separates an AND gate from an OR gate. Clearing the primary cascade bit while its cause is still pending shows that the bit is re-asserted. Freezing the pin while it is high, and again after the park-low sequence, shows that a held pin differs from a transparent one. The second part drives random mixes of events, clears and configuration toggles, with a behavioural model compared against the read port and the pin on every cycle.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned SEC_N      = 6;
  localparam int unsigned PRI_EXT_N  = 5;
  localparam int unsigned MASTER_BIT = 31;
  localparam int unsigned CASCADE_BIT = 0;

  localparam logic [REG_W-1:0] SEC_STAT_VALID = 32'h0000_007D;
  localparam logic [REG_W-1:0] SEC_EN_VALID   = SEC_STAT_VALID | (32'h1 << MASTER_BIT);
  localparam logic [REG_W-1:0] PRI_VALID      = 32'h0000_003F;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SEC_STAT = 3'd0,
    ADDR_SEC_EN   = 3'd1,
    ADDR_PRI_STAT = 3'd2,
    ADDR_PRI_EN   = 3'd3,
    ADDR_CFG      = 3'd4
  } reg_addr_e;

  // Secondary event k lands on status bit k, skipping bit 1.
  function automatic int unsigned sec_bit_pos(int unsigned k);
    return (k == 0) ? 0 : k + 1;
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] status_q;
  logic [W-1:0] status_d;
  logic [W-1:0] clr_vec;

  always_comb begin
    clr_vec  = clr_we_i ? clr_data_i : '0;
    status_d = (set_i | (status_q & ~clr_vec)) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  // R3: no write strobe means no set bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R3: an event beats a clear in the same cycle
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & VALID) != '0) |=> ((status_q & $past(set_i & VALID)) == $past(set_i & VALID)));

endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] STAT_VALID = '1,
  parameter logic [W-1:0] EN_VALID   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         stat_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         any_o
);

  logic [W-1:0] en_q;

  irq_status_bank #(.W(W), .VALID(STAT_VALID)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_i),
    .clr_we_i   (stat_we_i),
    .clr_data_i (wdata_i),
    .status_o   (status_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= wdata_i & EN_VALID;
  end

  assign enable_o = en_q;
  assign any_o    = |(status_o & en_q & STAT_VALID);

  // R7: with everything masked off, the group result is quiet
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & STAT_VALID) == '0) |-> !any_o);

endmodule

// File: rtl/irq_pin_hold.sv
module irq_pin_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic le_i,
  input  logic d_i,
  output logic q_o
);

  logic q_q;
  logic q_d;

  always_comb q_d = le_i ? d_i : q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R9: closed stage never moves
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !le_i |=> $stable(q_o));

  // R8: open stage follows with one cycle of delay
  a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
    le_i |=> (q_o == $past(d_i)));

endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irq_cascade_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEC_N-1:0]     sec_evt_i,
  input  logic [PRI_EXT_N-1:0] pri_evt_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 irq_o
);

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // Write decode
  logic we_sec_stat, we_sec_en, we_pri_stat, we_pri_en, we_cfg;

  always_comb begin
    we_sec_stat = reg_we_i && (reg_addr_i == ADDR_SEC_STAT);
    we_sec_en   = reg_we_i && (reg_addr_i == ADDR_SEC_EN);
    we_pri_stat = reg_we_i && (reg_addr_i == ADDR_PRI_STAT);
    we_pri_en   = reg_we_i && (reg_addr_i == ADDR_PRI_EN);
    we_cfg      = reg_we_i && (reg_addr_i == ADDR_CFG);
  end

  // Event placement
  logic [REG_W-1:0] sec_set;
  logic [REG_W-1:0] pri_set;
  logic             sec_fire;

  always_comb begin
    sec_set = '0;
    pri_set = '0;
    pri_set[CASCADE_BIT] = sec_fire;
    for (int unsigned k = 0; k < SEC_N; k++) begin
      sec_set[sec_bit_pos(k)] = sec_evt_i[k];
    end
    for (int unsigned k = 0; k < PRI_EXT_N; k++) begin
      pri_set[k+1] = pri_evt_i[k];
    end
  end

  // Secondary tier
  logic [REG_W-1:0] sec_stat, sec_en;
  logic             sec_any;

  irq_group #(.W(REG_W), .STAT_VALID(SEC_STAT_VALID), .EN_VALID(SEC_EN_VALID)) u_sec (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .set_i     (sec_set),
    .stat_we_i (we_sec_stat),
    .en_we_i   (we_sec_en),
    .wdata_i   (reg_wdata_i),
    .status_o  (sec_stat),
    .enable_o  (sec_en),
    .any_o     (sec_any)
  );

  assign sec_fire = sec_any & sec_en[MASTER_BIT];

  // Primary tier
  logic [REG_W-1:0] pri_stat, pri_en;
  logic             pri_any;

  irq_group #(.W(REG_W), .STAT_VALID(PRI_VALID), .EN_VALID(PRI_VALID)) u_pri (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .set_i     (pri_set),
    .stat_we_i (we_pri_stat),
    .en_we_i   (we_pri_en),
    .wdata_i   (reg_wdata_i),
    .status_o  (pri_stat),
    .enable_o  (pri_en),
    .any_o     (pri_any)
  );

  // Configuration: pin enable
  logic pin_en_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  pin_en_q <= 1'b0;
    else if (we_cfg)  pin_en_q <= reg_wdata_i[0];
  end

  irq_pin_hold u_pin (
    .clk   (clk),
    .rst_n (core_rst_n),
    .le_i  (pin_en_q),
    .d_i   (pri_any),
    .q_o   (irq_o)
  );

  // Read mux
  always_comb begin
    unique case (reg_addr_i)
      ADDR_SEC_STAT: reg_rdata_o = sec_stat;
      ADDR_SEC_EN:   reg_rdata_o = sec_en;
      ADDR_PRI_STAT: reg_rdata_o = pri_stat;
      ADDR_PRI_EN:   reg_rdata_o = pri_en;
      ADDR_CFG:      reg_rdata_o = {{(REG_W-1){1'b0}}, pin_en_q};
      default:       reg_rdata_o = '0;
    endcase
  end

  // R5: a qualified secondary cause shows in primary bit 0 on the next cycle
  a_r5_cascade: assert property (@(posedge clk) disable iff (!core_rst_n)
    sec_fire |=> pri_stat[CASCADE_BIT]);

  // R4: without the master bit, a clear cascade bit stays clear
  a_r4_master_gate: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!sec_en[MASTER_BIT] && !pri_stat[CASCADE_BIT] && !(pri_evt_i[0] && CASCADE_BIT == 1))
      |=> !pri_stat[CASCADE_BIT]);

  // R2: reserved secondary bits never set
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sec_stat & ~SEC_STAT_VALID) == '0);

  // R10: pin low and stage closed keeps it low
  a_r10_parked: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!irq_o && !pin_en_q && !we_cfg) |=> !irq_o);

endmodule

// File: tb/irq_cascade_top_tb.sv
`timescale 1ns/1ps
module irq_cascade_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  sec_evt;
  logic [4:0]  pri_evt;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_cascade_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_evt_i   (sec_evt),
    .pri_evt_i   (pri_evt),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_ss, m_se, m_ps, m_pe;
  logic        m_cfg, m_pin;

  always @(posedge clk) begin : model
    logic [31:0] sset, pset, clr_s, clr_p;
    logic        gated, por;
    if (!rst_n) begin
      m_ss = 0; m_se = 0; m_ps = 0; m_pe = 0; m_cfg = 0; m_pin = 0;
    end else begin
      sset = 0;
      for (int k = 0; k < 6; k++) if (sec_evt[k]) sset[(k == 0) ? 0 : k + 1] = 1'b1;
      gated = m_se[31] && ((m_ss & m_se & 32'h7D) != 0);
      pset = {26'd0, pri_evt, gated};
      por = (m_ps & m_pe & 32'h3F) != 0;
      clr_s = (we && addr == 3'd0) ? wdata : 32'd0;
      clr_p = (we && addr == 3'd2) ? wdata : 32'd0;
      if (m_cfg) m_pin = por;
      m_ss = ((m_ss & ~clr_s) | sset) & 32'h7D;
      m_ps = ((m_ps & ~clr_p) | pset) & 32'h3F;
      if (we && addr == 3'd1) m_se = wdata & 32'h8000_007D;
      if (we && addr == 3'd3) m_pe = wdata & 32'h3F;
      if (we && addr == 3'd4) m_cfg = wdata[0];
    end
  end

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_ss;
      3'd1: return m_se;
      3'd2: return m_ps;
      3'd3: return m_pe;
      3'd4: return {31'd0, m_cfg};
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R8 pin against model", {31'd0, irq}, {31'd0, m_pin});
      check("R11 read against model", rdata, exp_rd(addr));
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = 32'd0;
  endtask

  task automatic pulse_sec(logic [5:0] m);
    sec_evt = m; tick(); sec_evt = 6'd0;
  endtask

  task automatic pulse_pri(logic [4:0] m);
    pri_evt = m; tick(); pri_evt = 5'd0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
    addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic pin_chk(logic exp, string tag);
    #1;
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; sec_evt = 0; pri_evt = 0; we = 0; addr = 0; wdata = 0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    cmp_on = 1'b1;

    // R1 reset values
    for (int a = 0; a < 5; a++) rd_chk(a[2:0], 32'd0, "R1 reset read");
    pin_chk(1'b0, "R1 reset pin");

    // R2 bit placement
    pulse_sec(6'b111111);
    rd_chk(3'd0, 32'h7D, "R2 all six secondary events");
    wr(3'd0, 32'hFFFF_FFFF);
    pulse_sec(6'b100000);
    rd_chk(3'd0, 32'h40, "R2 last secondary event at bit 6");
    wr(3'd0, 32'h40);
    pulse_sec(6'b111111);

    // R3 clear rules
    wr(3'd0, 32'h01);
    rd_chk(3'd0, 32'h7C, "R3 write one clears");
    wr(3'd0, 32'h00);
    rd_chk(3'd0, 32'h7C, "R3 write zero keeps");
    sec_evt = 6'b000010;
    wr(3'd0, 32'h04);
    sec_evt = 6'd0;
    rd_chk(3'd0, 32'h7C, "R3 event beats clear");
    wr(3'd0, 32'h7F);
    rd_chk(3'd0, 32'h00, "R3 clear all");

    // R4 master gating
    wr(3'd1, 32'h04);
    pulse_sec(6'b000010);
    tick();
    rd_chk(3'd2, 32'h00, "R4 no master, no cascade");
    wr(3'd1, 32'h8000_0004);
    tick();
    rd_chk(3'd2, 32'h01, "R4 master on, cascade set");

    // R5 cascade re-asserts while pending
    wr(3'd2, 32'h01);
    rd_chk(3'd2, 32'h01, "R5 clear ignored while pending");
    wr(3'd0, 32'h04);
    wr(3'd2, 32'h01);
    rd_chk(3'd2, 32'h00, "R5 clear after cause gone");

    // R6 primary events
    pulse_pri(5'b10101);
    rd_chk(3'd2, 32'h2A, "R6 primary event placement");

    // R7/R8 pin path
    wr(3'd4, 32'h1);
    tick();
    pin_chk(1'b0, "R7 nothing enabled, pin low");
    wr(3'd3, 32'h02);
    pin_chk(1'b0, "R8 one cycle delay");
    tick();
    pin_chk(1'b1, "R8 pin follows");

    // R9 freeze high
    wr(3'd4, 32'h0);
    wr(3'd2, 32'h3F);
    tick();
    pin_chk(1'b1, "R9 pin held after clear");
    pulse_pri(5'b00001);
    tick();
    pin_chk(1'b1, "R9 pin held after event");

    // R10 park-low sequence
    wr(3'd4, 32'h1);
    wr(3'd2, 32'h3F);
    wr(3'd4, 32'h0);
    pulse_pri(5'b00001);
    tick(); tick();
    pin_chk(1'b0, "R10 pin parked low");
    rd_chk(3'd2, 32'h02, "R10 event still recorded");

    // R11 writable bits
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk(3'd1, 32'h8000_007D, "R11 secondary enable bits");
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk(3'd3, 32'h3F, "R11 primary enable bits");
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk(3'd4, 32'h1, "R11 config bit");
    rd_chk(3'd5, 32'h0, "R11 unused address");
    wr(3'd6, 32'hFFFF_FFFF);
    rd_chk(3'd7, 32'h0, "R11 unused address after write");

    // Random traffic compared with the model each cycle
    for (int i = 0; i < 600; i++) begin
      sec_evt = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
      pri_evt = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      we      = ($urandom % 3 == 0);
      addr    = 3'($urandom % 6);
      wdata   = ($urandom % 2) ? $urandom : 32'h8000_0000 | 32'($urandom % 128);
      tick();
    end
    we = 0; sec_evt = 0; pri_evt = 0;
    repeat (3) tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule